// File: doc/BRIEF.md
# Prescaled Serial Bit-Rate Generator

This block produces the timing strobes for an asynchronous serial port. A 2-bit source select picks what feeds the divider chain: the system clock itself, the system clock divided by 8, the system clock divided by 32, or the rising edges of an external clock pin. The external pin passes through a two-flop synchroniser before its edges are detected.

The chosen source advances an 8-bit reload down-counter that is loaded with a programmed value n. Each time the counter is at zero when the source fires, the block emits a single-cycle 16x oversampling strobe and reloads n. The total divide is therefore n+1. A fixed divide-by-16 stage after the counter produces the 1x bit strobe. A receiver or transmitter shifter consumes both strobes.

Software programs n and the source select through one write port. The select takes effect at once. A new n is used only at the next reload, so the period already running is never cut short.

Top module: `baud_gen`

## Requirements
- R1: The source select encoding is 0 = system clock, 1 = system clock / 8, 2 = system clock / 32, 3 = external clock rising edges. The /8 and /32 enables come from a free-running prescale counter, so they are evenly spaced.
- R2: With an internal source of divide d and value n, consecutive `tick16_o` pulses are d*(n+1) clock cycles apart.
- R3: With source 3, only rising edges of `ext_clk_i` advance the counter, after a two-flop synchroniser. An external clock of period P cycles gives `tick16_o` pulses P*(n+1) cycles apart. While an internal source is selected, activity on `ext_clk_i` has no effect on the strobe spacing.
- R4: `tick16_o` is a one-cycle pulse, issued once per counter reload.
- R5: `tick1_o` is high only in a cycle where `tick16_o` is high, and exactly once for every 16 `tick16_o` pulses.
- R6: A write of a new n does not alter the period in progress. The new value governs the periods that start after the next reload.
- R7: While `rst_ni` is low, both outputs are low. Reset sets n = 0, selects the undivided system clock and clears the prescale and divide-by-16 counters. After release, `tick16_o` is high in every cycle and the first `tick1_o` comes with the 16th `tick16_o`.
- R8: With source 0, `tick1_o` is spaced 16*(n+1) cycles apart. This gives the following rates:
  - n=47 gives 768 cycles, exactly 9600 bit/s at 7.3728 MHz.
  - n=15 gives 256 cycles, 28800 bit/s at 7.3728 MHz.
  - n=31 gives 512 cycles, exactly 31250 bit/s at 16 MHz.
  - n=103 gives 1664 cycles, about 9615 bit/s at 16 MHz.
- R9: One cycle with `wr_en_i` high loads both n (`wr_reload_i`) and the source select (`wr_src_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for reload value and source select |
| wr_reload_i | input | 8 | Reload value n |
| wr_src_i | input | 2 | Source select (R1 encoding) |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| tick16_o | output | 1 | 16x oversampling strobe |
| tick1_o | output | 1 | 1x bit strobe |

## Verification
The hardest case to reach is a reload value written partway through a long period. The old period must run to its end on the old value, and the next period must use the new one. The stimulus waits for an observed `tick16_o` with a large n loaded, writes a small n on the following cycle, and then times two consecutive intervals. External-source behaviour is reached by driving `ext_clk_i` from a bench generator with a chosen period. The generator keeps toggling during the internal-source trials as well, so any leakage of the pin into the count would show up as a spacing error.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
  import baud_pkg::*;
#(
  parameter int DIV_MID     = 8,   // power of two
  parameter int DIV_HI      = 32,  // power of two, >= DIV_MID
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_sel_e sel_i,
  input  logic     ext_clk_i,
  output logic     src_en_o,
  output logic     ext_edge_o
);
  localparam int MID_W = $clog2(DIV_MID);
  localparam int HI_W  = $clog2(DIV_HI);

  logic [HI_W-1:0]        pre_q;
  logic [SYNC_STAGES:0]   sync_q;  // top bit holds previous synchronised value

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_edge_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    unique case (sel_i)
      SRC_DIV1:  src_en_o = 1'b1;
      SRC_DIV8:  src_en_o = &pre_q[MID_W-1:0];
      SRC_DIV32: src_en_o = &pre_q;
      default:   src_en_o = ext_edge_o;
    endcase
  end
endmodule

// File: rtl/baud_reload_div.sv
module baud_reload_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= en_i && (cnt_q == '0);
      if (en_i) begin
        if (cnt_q == '0) cnt_q <= reload_i;  // new n only picked up here
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/baud_ovs_div.sv
module baud_ovs_div #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tick_o
);
  localparam int W = $clog2(OVS);
  localparam logic [W-1:0] LAST = W'(OVS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 2,
  parameter int DIV_MID     = 8,
  parameter int DIV_HI      = 32,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_reload_i,
  input  logic [SEL_W-1:0] wr_src_i,
  input  logic             ext_clk_i,
  output logic             tick16_o,
  output logic             tick1_o
);
  logic [CNT_W-1:0] n_q;
  src_sel_e         sel_q;
  logic             src_en;
  logic             ext_edge;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      sel_q <= SRC_DIV1;
    end else if (wr_en_i) begin
      n_q   <= wr_reload_i;
      sel_q <= src_sel_e'(wr_src_i);
    end
  end

  baud_src_sel #(
    .DIV_MID(DIV_MID), .DIV_HI(DIV_HI), .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_q), .ext_clk_i(ext_clk_i),
    .src_en_o(src_en), .ext_edge_o(ext_edge)
  );

  baud_reload_div #(.CNT_W(CNT_W)) u_reload (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(src_en), .reload_i(n_q),
    .tick_o(tick16_o), .cnt_o(cnt_q)
  );

  baud_ovs_div #(.OVS(OVS)) u_ovs (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_o), .tick_o(tick1_o)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic             src_en_i,
  input logic             ext_edge_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick16_i,
  input logic             tick1_i
);
  AST_DIV8_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1 && src_en_i) |=> (sel_i != 2'd1 || !src_en_i)); // R1
  AST_DIV32_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd2 && src_en_i) |=> (sel_i != 2'd2 || !src_en_i)); // R1
  AST_TICK_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick16_i |-> $past(src_en_i)); // R2
  AST_EXT_EDGE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_edge_i |=> !ext_edge_i); // R3
  AST_TICK16_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_i && cnt_i != '0) |=> !tick16_i); // R4
  AST_TICK1_IN_TICK16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick1_i |-> tick16_i); // R5
  AST_TICK1_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick1_i |=> !tick1_i); // R5
endmodule

bind baud_gen baud_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_q), .src_en_i(src_en),
  .ext_edge_i(ext_edge), .cnt_i(cnt_q), .tick16_i(tick16_o), .tick1_i(tick1_o)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_reload = '0;
  logic [1:0] wr_src = '0;
  logic       ext_clk = 1'b0;
  logic       tick16, tick1;

  int vectors = 0, miscompares = 0;
  int cyc = 0;
  int ext_half = 0, ext_cnt = 0;
  int t16_since = 0;
  bit done = 0;

  baud_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_reload_i(wr_reload),
    .wr_src_i(wr_src), .ext_clk_i(ext_clk), .tick16_o(tick16), .tick1_o(tick1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // external clock generator, period 2*ext_half cycles
  initial forever begin
    @(negedge clk);
    if (ext_half > 0) begin
      ext_cnt++;
      if (ext_cnt >= ext_half) begin ext_clk = ~ext_clk; ext_cnt = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: tick1 only alongside tick16, once per 16 tick16
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick16) t16_since++;
      if (tick1) begin
        check(tick16, "R5 tick1 without tick16", 0, 1);
        check(t16_since == 16, "R5 tick16 count per tick1", t16_since, 16);
        t16_since = 0;
      end
    end else t16_since = 0;
  end

  function automatic int div_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 8 : 32;
  endfunction

  task automatic write_cfg(input int n, input int s);
    @(negedge clk);
    wr_en = 1'b1; wr_reload = 8'(n); wr_src = 2'(s);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait16(output int t);
    do @(negedge clk); while (!tick16);
    t = cyc;
  endtask

  task automatic wait1(output int t);
    do @(negedge clk); while (!tick1);
    t = cyc;
  endtask

  task automatic meas16(output int iv);
    int a, b;
    wait16(a); wait16(a); wait16(a); wait16(b);
    iv = b - a;
  endtask

  task automatic meas1(output int iv);
    int a, b;
    wait1(a); wait1(a); wait1(b);
    iv = b - a;
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int iv, a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!tick16 && !tick1, "R7 outputs low in reset", int'(tick16) + int'(tick1), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tick16, "R7 tick16 every cycle after reset", int'(tick16), 1);
    end
    wait1(a); wait1(b);
    check(b - a == 16, "R7 tick1 spacing after reset", b - a, 16);

    // R8 exact rate cases
    write_cfg(47, 0); meas1(iv); check(iv == 768, "R8 n=47 9600 bit/s", iv, 768);
    write_cfg(15, 0); meas1(iv); check(iv == 256, "R8 n=15 28800 bit/s", iv, 256);
    write_cfg(31, 0); meas1(iv); check(iv == 512, "R8 n=31 31250 bit/s", iv, 512);
    write_cfg(103, 0); meas1(iv); check(iv == 1664, "R8 n=103 ~9615 bit/s", iv, 1664);

    // R1/R2 each internal prescale, ext toggling must not matter (R3)
    ext_half = 2;
    write_cfg(103, 1); meas16(iv); check(iv == 832, "R1 div8 n=103", iv, 832);
    write_cfg(4, 2); meas16(iv); check(iv == 160, "R1 div32 n=4", iv, 160);
    write_cfg(0, 1); meas16(iv); check(iv == 8, "R2 div8 n=0", iv, 8);
    // R9 single write sets both fields
    write_cfg(9, 1); meas16(iv); check(iv == 80, "R9 combined write", iv, 80);
    // R3 external source
    ext_half = 3; write_cfg(5, 3); meas16(iv); check(iv == 36, "R3 ext period 6 n=5", iv, 36);
    ext_half = 1; write_cfg(0, 3); meas16(iv); check(iv == 2, "R3 ext period 2 n=0", iv, 2);
    ext_half = 0; ext_clk = 1'b1;
    repeat (5) @(negedge clk);
    a = cyc;
    repeat (60) begin @(negedge clk); if (tick16) a = -1; end
    check(a >= 0, "R3 steady-high pin gives no count", (a < 0) ? 1 : 0, 0);
    ext_clk = 1'b0; ext_half = 2;

    // R6 write lands mid-period
    write_cfg(200, 0); meas16(iv); check(iv == 201, "R6 setup n=200", iv, 201);
    wait16(a);
    write_cfg(3, 0);
    wait16(b); check(b - a == 201, "R6 current period kept", b - a, 201);
    wait16(a); check(a - b == 4, "R6 new n after reload", a - b, 4);
    // R4 single-cycle pulse
    @(negedge clk); check(!tick16, "R4 tick16 one cycle", int'(tick16), 0);

    // random trials
    for (int t = 0; t < 14; t++) begin
      int s, n, exp;
      s = $urandom_range(0, 3);
      if (s == 3) begin
        ext_half = $urandom_range(1, 3); n = $urandom_range(0, 15);
        exp = 2 * ext_half * (n + 1);
      end else begin
        ext_half = $urandom_range(1, 4); n = $urandom_range(0, (s == 2) ? 31 : 63);
        exp = div_of(s) * (n + 1);
      end
      write_cfg(n, s); meas16(iv);
      check(iv == exp, (s == 3) ? "R3 random ext" : "R2 random internal", iv, exp);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule